// File: doc/BRIEF.md
# Interleaved Chroma Phase Tracker

This block follows the sample phase of an interleaved video stream, so that downstream logic knows which word on the bus is Cb, which is Cr and, in single-channel 4:2:2 operation, which is luma. A falling edge on the sync strobe marks the sample after it as Cb. Between strobes the tracker advances the phase by itself: it alternates Cb and Cr for two-channel interleaved chroma, and steps Cb, Y, Cr, Y for single-channel 4:2:2 video.

It also produces a clock enable for the core. When single-channel 4:2:2 video is selected, the core runs at half the master rate, and reset fixes which master edge carries the enable. The enable is high on every cycle when interleaved chroma is selected. If a strobe edge lands on a phase other than the one the tracker predicted, the phase is forced to Cb and an error flag is raised for one cycle. The first strobe after reset only sets the phase and never raises the flag.

Top module: `chroma_phase_tracker`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the outputs after that edge are `phase_o` = 4'b0001 (Cb), `half_en_o` = 0 and `sync_err_o` = 0.
- R2: With `mode_422_i` = 1, `half_en_o` is 1 after the first rising edge on which `rst` is low. It then inverts on every following edge.
- R3: On any edge that samples `mode_422_i` = 0 with reset low, `half_en_o` is 1 after that edge.
- R4: `phase_o` is one-hot: bit 0 = Cb, bit 1 = Y following Cb, bit 2 = Cr, bit 3 = Y following Cr.
- R5: With `mode_422_i` = 1 and no strobe edge, each edge advances the phase one step in the order Cb, Y, Cr, Y, Cb.
- R6: With `mode_422_i` = 0 and no strobe edge, the phase becomes Cr after an edge if it was Cb before it, and Cb otherwise. Bits 1 and 3 stay low.
- R7: A strobe edge is `sync_i` sampled high on one rising edge (with reset low) and low on the next. After that second edge, `phase_o` shows Cb in either mode.
- R8: When `sync_i` holds a level and makes no high-to-low change, it does not alter the phase sequence of R5/R6.
- R9: A strobe edge raises `sync_err_o` for exactly the following cycle when a strobe edge has already been seen since reset and the phase R5/R6 would have produced is not Cb. A strobe edge that agrees with the prediction leaves `sync_err_o` at 0.
- R10: The first strobe edge after reset never raises `sync_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Sync strobe; a high-to-low change marks Cb |
| mode_422_i | input | 1 | 1 = single-channel 4:2:2 interleaved, 0 = two-channel interleaved chroma |
| half_en_o | output | 1 | Core clock enable |
| phase_o | output | 4 | One-hot sample phase (Cb, Y, Cr, Y) |
| sync_err_o | output | 1 | One-cycle pulse when a strobe disagrees with the predicted phase |

## Verification
The hardest case to reach is a strobe that arrives on a mismatched phase after the tracker is already locked. To produce one, the strobe must be raised and dropped at a chosen offset from an earlier strobe. The bench therefore sweeps that offset over every phase in both modes, one strobe after another. It also switches modes while the phase sits on a luma step, and it applies long pseudo-random runs of strobes, mode changes and resets. A cycle-level model in the bench, written from the requirements, predicts every output.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PW = $clog2(NUM_PHASES);
  typedef logic [PW-1:0] phase_t;
  localparam phase_t PH_CB = phase_t'(0);
  localparam phase_t PH_Y0 = phase_t'(1);
  localparam phase_t PH_CR = phase_t'(2);
  localparam phase_t PH_Y1 = phase_t'(3);
endpackage

// File: rtl/cpt_sync_edge.sv
module cpt_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic fall_o
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= sync_i;
  end

  assign fall_o = sync_q & ~sync_i;

  // R7: a detected edge needs the strobe high one sample earlier
  p_fall_after_high_r7: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> $past(sync_i));
endmodule

// File: rtl/cpt_half_rate.sv
module cpt_half_rate (
  input  logic clk,
  input  logic rst,
  input  logic mode_422_i,
  output logic half_en_o
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= 1'b0;
      half_en_o <= 1'b0;
    end else begin
      ph_q      <= ~ph_q;
      half_en_o <= mode_422_i ? ~ph_q : 1'b1;
    end
  end

  p_full_rate_r3: assert property (@(posedge clk) disable iff (rst)
    !mode_422_i |=> half_en_o);
  p_half_low_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_422_i && ph_q) |=> !half_en_o);
  p_half_high_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_422_i && !ph_q) |=> half_en_o);
endmodule

// File: rtl/cpt_phase_seq.sv
module cpt_phase_seq
  import cpt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fall_i,
  input  logic                  mode_422_i,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  err_o
);
  phase_t cnt_q;
  phase_t cnt_nx;
  logic   seen_q;

  always_comb begin
    if (mode_422_i) cnt_nx = cnt_q + phase_t'(1);
    else            cnt_nx = (cnt_q == PH_CB) ? PH_CR : PH_CB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= PH_CB;
      seen_q <= 1'b0;
      err_o  <= 1'b0;
    end else if (fall_i) begin
      cnt_q  <= PH_CB;
      seen_q <= 1'b1;
      err_o  <= seen_q && (cnt_nx != PH_CB);
    end else begin
      cnt_q  <= cnt_nx;
      err_o  <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dec
    assign phase_o[g] = (cnt_q == phase_t'(g));
  end

  p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o) == 1);
  p_fall_to_cb_r7: assert property (@(posedge clk) disable iff (rst)
    fall_i |=> phase_o[PH_CB]);
  p_chroma_no_luma_r6: assert property (@(posedge clk) disable iff (rst)
    !mode_422_i |=> (!phase_o[PH_Y0] && !phase_o[PH_Y1]));
  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_422_i && !fall_i) |=> (phase_o != $past(phase_o)));
  p_err_on_cb_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> phase_o[PH_CB]);
  p_err_single_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
endmodule

// File: rtl/chroma_phase_tracker.sv
module chroma_phase_tracker
  import cpt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sync_i,
  input  logic                  mode_422_i,
  output logic                  half_en_o,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  sync_err_o
);
  logic fall;

  cpt_sync_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_i),
    .fall_o (fall)
  );

  cpt_phase_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .fall_i     (fall),
    .mode_422_i (mode_422_i),
    .phase_o    (phase_o),
    .err_o      (sync_err_o)
  );

  cpt_half_rate u_half (
    .clk        (clk),
    .rst        (rst),
    .mode_422_i (mode_422_i),
    .half_en_o  (half_en_o)
  );

  // R10: the first strobe after reset leaves the error flag low
  p_first_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (fall && !u_seq.seen_q) |=> !sync_err_o);
endmodule

// File: tb/chroma_phase_tracker_tb.sv
module chroma_phase_tracker_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       sync_i = 1'b0;
  logic       mode_422_i = 1'b0;
  logic       half_en_o;
  logic [3:0] phase_o;
  logic       sync_err_o;

  chroma_phase_tracker u_dut (
    .clk        (clk),
    .rst        (rst),
    .sync_i     (sync_i),
    .mode_422_i (mode_422_i),
    .half_en_o  (half_en_o),
    .phase_o    (phase_o),
    .sync_err_o (sync_err_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  int m_cnt  = 0;
  bit m_seen = 0;
  bit m_ph   = 0;
  bit m_half = 0;
  bit m_err  = 0;
  bit m_sq   = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge: drive, let one rising edge pass, then compare
  task automatic step(input bit r, input bit s, input bit m);
    string t_ph, t_err, t_half;
    bit fall, held;
    int nxt;
    rst = r; sync_i = s; mode_422_i = m;
    @(posedge clk);
    if (r) begin
      m_cnt = 0; m_seen = 0; m_ph = 0; m_half = 0; m_err = 0; m_sq = 0;
      t_ph = "R1 phase"; t_err = "R1 err"; t_half = "R1 half_en";
    end else begin
      fall = m_sq && !s;
      held = (m_sq == s) && s;
      nxt  = m ? (m_cnt + 1) % 4 : ((m_cnt == 0) ? 2 : 0);
      if (fall) begin
        t_err = m_seen ? "R9 err" : "R10 err";
        m_err = m_seen && (nxt != 0);
        m_cnt = 0; m_seen = 1;
        t_ph  = "R7 phase";
      end else begin
        m_err = 0; m_cnt = nxt;
        t_err = "R9 err idle";
        t_ph  = held ? "R8 phase" : (m ? "R5 phase" : "R6 phase");
      end
      m_half = m ? !m_ph : 1'b1;
      t_half = m ? "R2 half_en" : "R3 half_en";
      m_ph = !m_ph;
      m_sq = s;
    end
    @(negedge clk);
    chk(t_ph, int'(phase_o), 1 << m_cnt);
    chk("R4 onehot", $countones(phase_o), 1);
    chk(t_half, int'(half_en_o), int'(m_half));
    chk(t_err, int'(sync_err_o), int'(m_err));
  endtask

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    // held-high strobe, then the first edge, then free run in 4:2:2
    for (int i = 0; i < 6; i++) step(0, 1, 1);
    step(0, 0, 1);
    for (int i = 0; i < 9; i++) step(0, 0, 1);
    // offset sweep: strobe at every phase in both modes
    for (int m = 0; m < 2; m++)
      for (int off = 0; off < 5; off++) begin
        for (int k = 0; k < off; k++) step(0, 0, m[0]);
        step(0, 1, m[0]);
        step(0, 0, m[0]);
        for (int k = 0; k < 3; k++) step(0, 0, m[0]);
      end
    // strobe toggled on every Cb in 4:2:2 and in chroma mode
    for (int i = 0; i < 16; i++) step(0, (i % 4) == 2, 1);
    for (int i = 0; i < 12; i++) step(0, (i % 2) == 1, 0);
    // leave 4:2:2 on a luma phase and enter chroma mode
    step(1, 0, 1);
    step(0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    // reset mid-stream realigns the half-rate enable
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    step(1, 0, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 1);
    // pseudo-random run
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[9:0] == 10'd5, lf[0] & lf[3], lf[7] | lf[11]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule